// File: doc/BRIEF.md
# Vector Element-Enable Mask Generator

This block produces a 64-bit element-enable mask for one vector operation. A requester offers a 4-bit mode code, the vector length and the current values of three scalar registers (called here r3, r10 and r30) on a valid/ready request port. Integer-sourced modes build the mask from those register values in a single step. Condition-sourced modes walk a set of external 4-bit condition fields, one field per element, through a read port, and collect one chosen bit from each field.

Requests use a valid/ready handshake. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. The requester must hold all request fields steady while `req_valid` is high and `req_ready` is low. `req_ready` drops while a condition walk is in progress, so only one request is ever in flight. The result has no back-pressure. `done` is high for one cycle per request, and `mask` holds the result from that cycle until the next `done`.

The mode code is split into fields. Bit 3 chooses condition mode. In condition mode, bits 2:1 give the bit index within each field and bit 0 asks for inversion. In integer mode, bits 2:1 choose the register (01 r3, 10 r10, 11 r30) and bit 0 asks for inversion. The 00 selection is special: code 0 gives all ones and code 1 gives the one-hot form.

Top module: `pmg_mask_gen`

## Requirements
- R1: `req_ready` is high after reset and whenever no condition walk is running. It is low from the cycle after a condition-mode request with VL of 1 or more is taken until that walk's `done` cycle. After reset `done` is low and `mask` is zero.
- R2: Code 0 yields a mask of all ones, whatever the register values.
- R3: Code 1 yields a one-hot mask whose single set bit is at the position held in r3 bits 5:0. Upper r3 bits have no effect.
- R4: Codes 2, 4 and 6 yield r3, r10 and r30 unchanged. Codes 3, 5 and 7 yield their bitwise inverse.
- R5: Codes 8 to 15 are condition modes. For element i, mask bit i equals bit `code[2:1]` of condition field i, XORed with `code[0]`. Code 8 is the less-than test (bit 0, not inverted). Code 15 is the inverted summary-overflow test (bit 3, inverted).
- R6: A condition-mode request with VL ≥ 1 reads fields 0 to VL-1 in order, one per cycle, through `cr_idx`. `done` is high in the cycle after the VL-th clock edge that follows the accepting edge.
- R7: In condition mode, mask bits at positions VL and above are zero.
- R8: A condition-mode request with VL = 0 yields an all-zero mask. Like an integer-mode request, it raises `done` in the cycle right after the accepting edge, and `req_ready` stays high.
- R9: `mask` changes only in a cycle where `done` is high, and keeps its value while `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_mode | input | 4 | Mode code |
| req_vl | input | 7 | Vector length, 0 to 64 |
| reg_r3 | input | 64 | Value of scalar register r3 |
| reg_r10 | input | 64 | Value of scalar register r10 |
| reg_r30 | input | 64 | Value of scalar register r30 |
| cr_idx | output | 6 | Index of the condition field being read |
| cr_field | input | 4 | Contents of the field at `cr_idx`, same cycle |
| mask | output | 64 | Element-enable mask |
| done | output | 1 | One-cycle strobe: `mask` is the new result |

## Verification
The assertions assume that the VL on any accepted condition-mode request is at most 64. They also assume that `cr_field` returns the field addressed by `cr_idx` in the same cycle and does not change for the length of a walk. The stimulus draws VL from 0 to 64 only. It models the field store as an array read combinationally at `cr_idx`, and it refills that array only after the request queue has drained and `req_ready` is high. Register values are random on every request and are held only until the request is taken.

// File: rtl/pmg_pkg.sv
package pmg_pkg;

  localparam int unsigned FIELD_W = 4;

  typedef struct packed {
    logic       is_cr;
    logic [1:0] sel;
    logic       inv;
  } mode_t;

  function automatic mode_t decode_mode(input logic [3:0] code);
    mode_t m;
    m.is_cr = code[3];
    m.sel   = code[2:1];
    m.inv   = code[0];
    return m;
  endfunction

endpackage

// File: rtl/pmg_int_sel.sv
module pmg_int_sel
  import pmg_pkg::*;
#(
  parameter int MASK_W = 64,
  localparam int SH_W = $clog2(MASK_W)
) (
  input  mode_t             md,
  input  logic [MASK_W-1:0] r3,
  input  logic [MASK_W-1:0] r10,
  input  logic [MASK_W-1:0] r30,
  output logic [MASK_W-1:0] mask
);

  logic [MASK_W-1:0] onehot;
  logic [MASK_W-1:0] picked;

  // one-hot decoder of the low r3 bits
  for (genvar i = 0; i < MASK_W; i++) begin : g_hot
    assign onehot[i] = (r3[SH_W-1:0] == SH_W'(i));
  end

  always_comb begin
    unique case (md.sel)
      2'd1:    picked = r3;
      2'd2:    picked = r10;
      2'd3:    picked = r30;
      default: picked = '0;
    endcase
    if (md.sel == 2'd0) begin
      mask = md.inv ? onehot : {MASK_W{1'b1}};
    end else begin
      mask = md.inv ? ~picked : picked;
    end
  end

  // R3: the unary form always has exactly one bit set
  always_comb begin
    if (!md.is_cr && md.sel == 2'd0 && md.inv) begin
      a_r3_onehot: assert ($countones(mask) == 1);
    end
  end

endmodule

// File: rtl/pmg_cr_walk.sv
module pmg_cr_walk
  import pmg_pkg::*;
#(
  parameter int MASK_W = 64,
  localparam int VL_W  = $clog2(MASK_W + 1),
  localparam int IDX_W = $clog2(MASK_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         bit_sel,
  input  logic               inv,
  input  logic [VL_W-1:0]    vl,
  input  logic [FIELD_W-1:0] cr_field,
  output logic [IDX_W-1:0]   cr_idx,
  output logic               busy,
  output logic               fin,
  output logic [MASK_W-1:0]  mask_out
);

  logic              busy_q;
  logic [IDX_W-1:0]  idx_q;
  logic [VL_W-1:0]   last_q;
  logic [1:0]        bit_q;
  logic              inv_q;
  logic [MASK_W-1:0] acc_q;
  logic [MASK_W-1:0] acc_next;
  logic              bitv;

  assign bitv   = cr_field[bit_q] ^ inv_q;
  assign fin    = busy_q && (VL_W'(idx_q) == last_q);
  assign busy   = busy_q;
  assign cr_idx = idx_q;

  // only the element under visit takes the new bit
  for (genvar i = 0; i < MASK_W; i++) begin : g_acc
    assign acc_next[i] = (busy_q && idx_q == IDX_W'(i)) ? bitv : acc_q[i];
  end

  assign mask_out = acc_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      bit_q  <= '0;
      inv_q  <= 1'b0;
      acc_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      last_q <= vl - VL_W'(1);
      bit_q  <= bit_sel;
      inv_q  <= inv;
      acc_q  <= '0;
    end else if (busy_q) begin
      acc_q <= acc_next;
      if (fin) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  // R6: the walk visits fields in order, one per cycle
  a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fin) |=> (busy_q && idx_q == $past(idx_q) + IDX_W'(1)));

  // R7: nothing is collected at or above the element under visit
  a_r7_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((acc_q >> idx_q) == '0));

endmodule

// File: rtl/pmg_mask_gen.sv
module pmg_mask_gen
  import pmg_pkg::*;
#(
  parameter int MASK_W = 64,
  localparam int VL_W  = $clog2(MASK_W + 1),
  localparam int IDX_W = $clog2(MASK_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [3:0]         req_mode,
  input  logic [VL_W-1:0]    req_vl,
  input  logic [MASK_W-1:0]  reg_r3,
  input  logic [MASK_W-1:0]  reg_r10,
  input  logic [MASK_W-1:0]  reg_r30,
  output logic [IDX_W-1:0]   cr_idx,
  input  logic [FIELD_W-1:0] cr_field,
  output logic [MASK_W-1:0]  mask,
  output logic               done
);

  mode_t             md;
  logic              accept;
  logic              walk_start;
  logic              walk_busy;
  logic              walk_fin;
  logic [MASK_W-1:0] int_mask;
  logic [MASK_W-1:0] walk_mask;
  logic [MASK_W-1:0] mask_q;
  logic              done_q;

  assign md         = decode_mode(req_mode);
  assign req_ready  = !walk_busy;
  assign accept     = req_valid && req_ready;
  assign walk_start = accept && md.is_cr && (req_vl != '0);

  pmg_int_sel #(.MASK_W(MASK_W)) u_int_sel (
    .md   (md),
    .r3   (reg_r3),
    .r10  (reg_r10),
    .r30  (reg_r30),
    .mask (int_mask)
  );

  pmg_cr_walk #(.MASK_W(MASK_W)) u_cr_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (walk_start),
    .bit_sel  (md.sel),
    .inv      (md.inv),
    .vl       (req_vl),
    .cr_field (cr_field),
    .cr_idx   (cr_idx),
    .busy     (walk_busy),
    .fin      (walk_fin),
    .mask_out (walk_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept && !md.is_cr) begin
        mask_q <= int_mask;
        done_q <= 1'b1;
      end else if (accept && md.is_cr && req_vl == '0) begin
        mask_q <= '0;
        done_q <= 1'b1;
      end else if (walk_fin) begin
        mask_q <= walk_mask;
        done_q <= 1'b1;
      end
    end
  end

  assign mask = mask_q;
  assign done = done_q;

  // R6: input rule, VL never exceeds the mask width
  a_r6_vl_range: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && md.is_cr) |-> (req_vl <= VL_W'(MASK_W)));

  // R2: the all-ones code finishes at once with every bit set
  a_r2_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode == 4'd0) |=> (done && (&mask)));

  // R8: zero length in condition mode gives an empty mask at once
  a_r8_vl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && md.is_cr && req_vl == '0) |=> (done && mask == '0));

  // R9: the result moves only together with the strobe
  a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask) |-> done);

  // R1: no request is taken while a walk runs
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |-> !walk_start);

endmodule

// File: tb/pmg_mask_gen_bench.sv
`timescale 1ns/1ps
module pmg_mask_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_mode = '0;
  logic [6:0]  req_vl = '0;
  logic [63:0] reg_r3 = '0, reg_r10 = '0, reg_r30 = '0;
  logic [5:0]  cr_idx;
  logic [3:0]  cr_field;
  logic [63:0] mask;
  logic        done;

  logic [3:0]  cr_mem [64];
  int          cyc = 0;
  int          n_total = 0;
  int          n_fail = 0;

  typedef struct {
    logic [63:0] m;
    int          due;
    int          mode;
    int          vl;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign cr_field = cr_mem[cr_idx];

  pmg_mask_gen u_pmg_mask_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_vl(req_vl), .reg_r3(reg_r3),
    .reg_r10(reg_r10), .reg_r30(reg_r30), .cr_idx(cr_idx),
    .cr_field(cr_field), .mask(mask), .done(done)
  );

  function automatic string tag_of(int mode, int vl);
    if (mode == 0) return "R2";
    if (mode == 1) return "R3";
    if (mode < 8)  return "R4";
    if (vl == 0)   return "R8";
    return "R5";
  endfunction

  function automatic logic [63:0] ref_mask(int mode, int vl,
      logic [63:0] a, logic [63:0] b, logic [63:0] c);
    logic [63:0] r;
    r = '0;
    case (mode)
      0: r = '1;
      1: r = 64'd1 << a[5:0];
      2: r = a;   3: r = ~a;
      4: r = b;   5: r = ~b;
      6: r = c;   7: r = ~c;
      default: begin
        for (int i = 0; i < vl; i++)
          r[i] = cr_mem[i][(mode >> 1) & 3] ^ mode[0];
      end
    endcase
    return r;
  endfunction

  task automatic check(bit ok, string req, string what,
                       logic [63:0] act, logic [63:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: offers one request, pushes the expected result
  task automatic send(int mode, int vl, logic [63:0] a, logic [63:0] b,
                      logic [63:0] c);
    exp_t e;
    bit walks;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_mode  = 4'(mode);
    req_vl    = 7'(vl);
    reg_r3    = a;
    reg_r10   = b;
    reg_r30   = c;
    e.m    = ref_mask(mode, vl, a, b, c);
    e.mode = mode;
    e.vl   = vl;
    walks  = (mode >= 8) && (vl > 0);
    @(posedge clk);
    #1;
    e.due = walks ? cyc + vl : cyc;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    reg_r3    = {$urandom, $urandom};
    // R1: ready drops only for a running walk
    check(req_ready == !walks, walks ? "R1" : "R8", "ready after accept",
          64'(req_ready), 64'(!walks));
  endtask

  task automatic send_rand(int mode, int vl);
    send(mode, vl, {$urandom, $urandom}, {$urandom, $urandom},
         {$urandom, $urandom});
  endtask

  task automatic drain();
    while (q.size() != 0 || !req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic fill_cr();
    for (int i = 0; i < 64; i++) cr_mem[i] = 4'($urandom);
  endtask

  // monitor: pops and compares whenever the strobe is seen
  bit          hold_pend = 0;
  logic [63:0] hold_val;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (q.size() == 0) begin
          check(1'b0, "R9", "done with nothing pending", 64'(1), 64'(0));
        end else begin
          exp_t e;
          e = q.pop_front();
          check(mask === e.m, tag_of(e.mode, e.vl), "mask", mask, e.m);
          check(cyc == e.due, (e.mode >= 8 && e.vl > 0) ? "R6" :
                tag_of(e.mode, e.vl), "done cycle", 64'(cyc), 64'(e.due));
          if (e.mode >= 8 && e.vl < 64)
            check((mask >> e.vl) == '0, "R7", "bits above VL", mask, '0);
        end
        hold_pend = 1;
        hold_val  = mask;
      end else if (hold_pend) begin
        check(mask === hold_val, "R9", "mask held", mask, hold_val);
        hold_pend = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    fill_cr();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && mask == '0 && req_ready == 1'b1, "R1",
          "reset state", {mask[61:0], done, req_ready}, 64'd1);

    // integer modes, directed then random
    send(0, 5, '0, '0, '0);                                        // R2
    send(1, 0, 64'hFFFF_FFFF_FFFF_FFC5, '0, '0);                   // R3 -> bit 5
    send(1, 0, 64'h0000_0000_0000_003F, '0, '0);                   // R3 -> bit 63
    for (int m = 0; m < 8; m++) send_rand(m, $urandom_range(0, 64)); // R4
    drain();

    // condition modes over several lengths (R5, R6, R7, R8)
    for (int m = 8; m < 16; m++) begin
      fill_cr();
      send_rand(m, 1);
      send_rand(m, 2);
      send_rand(m, 5);
      send_rand(m, 0);
      send_rand(m, 63);
      send_rand(m, 64);
      drain();
    end

    // mixed random traffic, back to back
    for (int k = 0; k < 20; k++) begin
      fill_cr();
      for (int j = 0; j < 8; j++)
        send_rand($urandom_range(0, 15), $urandom_range(0, 64));
      drain();
    end

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule